// File: doc/BRIEF.md
# General-Purpose I/O Port with Change and Edge Interrupt Flags

This block is one 8-bit bidirectional I/O port. Each pin has a direction bit and an output latch bit. A small register bus writes and reads the port data and the direction. Software reads the port to see the pin levels. It writes the port to set the output latch. It writes the direction register to choose, pin by pin, whether the pin drives or listens.

Weak pull-ups turn on for pins configured as inputs when a global active-low enable is low. Every pin input passes through a two-flop synchronizer.

The block raises two flags for an interrupt controller, which is not part of this block:
- The change flag covers the upper four pins. It rises while any of those pins, when configured as an input, differs from the snapshot taken at the last port access.
- The edge flag watches pin 0. The edge that sets it, rising or falling, is selected by an input.

Both flags are set without regard to any enable. Each flag is cleared by its own clear strobe.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset every direction bit is 1 (all pins are inputs, `pinOe` = 0x00), the output latch is 0x00, and both flags are 0.
- R2: A direction bit of 1 turns that pin's output enable off. A direction bit of 0 turns it on, and `pinOut` always carries the output latch.
- R3: A port write (`busEn`=1, `busWe`=1, `busAddr`=0) changes only the output latch. A port read (`busAddr`=0) returns the synchronized pin levels, which follow a pin change after two clock edges, and never the latch.
- R4: A direction write (`busAddr`=1) loads the direction register from the next edge on. A direction read returns that register.
- R5: `pullEn[i]` is 1 exactly when `pullupOffN` is 0 and pin i is configured as an input.
- R6: When an input pin among bits 7:4 differs from the snapshot taken at the last port access, `chgFlag` reads 1 after the third clock edge following the pin change. Pins 3:0 never affect `chgFlag`.
- R7: An upper pin configured as an output (direction 0) is left out of the change comparison.
- R8: A port read or a port write captures a new snapshot and so ends the mismatch. A `chgClr` pulse after that leaves `chgFlag` at 0.
- R9: A `chgClr` pulse while the mismatch still persists leaves `chgFlag` at 1, because a set wins over a clear in the same cycle.
- R10: With `extRise`=1, a rising edge on pin 0 sets `extFlag` after the third clock edge following it. A falling edge does not set it.
- R11: With `extRise`=0, a falling edge on pin 0 sets `extFlag`. A rising edge does not set it. `extClr` clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busEn | input | 1 | Bus access strobe, one cycle per access |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 1 | 0 = port data, 1 = direction register |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational, valid while busEn is high) |
| pullupOffN | input | 1 | Global pull-up enable, active low |
| extRise | input | 1 | Pin 0 edge select: 1 = rising, 0 = falling |
| chgClr | input | 1 | Software clear of the change flag |
| extClr | input | 1 | Software clear of the edge flag |
| pinIn | input | 8 | Pad input levels |
| pinOe | output | 8 | Pad output enables |
| pinOut | output | 8 | Pad output data |
| pullEn | output | 8 | Weak pull-up enables |
| chgFlag | output | 1 | Change flag for bits 7:4 |
| extFlag | output | 1 | Pin 0 edge flag |

## Verification
A software clear of the change flag can land in the same cycle as a live mismatch. A port access can also land in the cycle where the mismatch is still being seen. The bench provokes the first case by pulsing `chgClr` while an upper input pin still differs from the snapshot. It expects `chgFlag` to stay at 1. It provokes the second case with a port read or write in the cycle the flag is set, followed by a clear. There the flag must drop to 0 and stay there, which shows that the access, and not the clear, ended the mismatch.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
  typedef struct packed {
    logic portRd;
    logic portWr;
    logic dirRd;
    logic dirWr;
    logic chgClr;
    logic extClr;
  } strobe_t;
endpackage

// File: rtl/gpio_chg_ctrl.sv
module gpio_chg_ctrl
  import gpio_chg_pkg::*;
(
  input  logic    busEn,
  input  logic    busWe,
  input  logic    busAddr,
  input  logic    chgClrIn,
  input  logic    extClrIn,
  output strobe_t str
);
  always_comb begin
    str.portRd = busEn & ~busWe & ~busAddr;
    str.portWr = busEn &  busWe & ~busAddr;
    str.dirRd  = busEn & ~busWe &  busAddr;
    str.dirWr  = busEn &  busWe &  busAddr;
    str.chgClr = chgClrIn;
    str.extClr = extClrIn;
  end
endmodule

// File: rtl/gpio_chg_dp.sv
module gpio_chg_dp
  import gpio_chg_pkg::*;
#(
  parameter int W       = 8,
  parameter int CHG_LSB = 4,
  parameter int EXT_BIT = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  strobe_t      str,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         pullupOffN,
  input  logic         extRise,
  input  logic [W-1:0] pinIn,
  output logic [W-1:0] pinOe,
  output logic [W-1:0] pinOut,
  output logic [W-1:0] pullEn,
  output logic         chgFlag,
  output logic         extFlag
);
  localparam int CW = W - CHG_LSB;

  logic [W-1:0]  dirReg, latReg, syncA, pinSync;
  logic [CW-1:0] snap, diffBits;
  logic          mismatch, extPrev, extEdge;

  // direction and output latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirReg <= '1;
      latReg <= '0;
    end else begin
      if (str.dirWr)  dirReg <= wdata;
      if (str.portWr) latReg <= wdata;
    end
  end

  // two-flop input synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA   <= '0;
      pinSync <= '0;
    end else begin
      syncA   <= pinIn;
      pinSync <= syncA;
    end
  end

  assign pinOe  = ~dirReg;
  assign pinOut = latReg;
  assign pullEn = dirReg & {W{~pullupOffN}};

  always_comb begin
    rdata = '0;
    if (str.portRd)     rdata = pinSync;
    else if (str.dirRd) rdata = dirReg;
  end

  // change detector on the upper pins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        snap <= '0;
    else if (str.portRd || str.portWr) snap <= pinSync[W-1:CHG_LSB];
  end

  genvar gi;
  generate
    for (gi = 0; gi < CW; gi++) begin : g_cmp
      assign diffBits[gi] = dirReg[CHG_LSB+gi] & (pinSync[CHG_LSB+gi] ^ snap[gi]);
    end
  endgenerate
  assign mismatch = |diffBits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          chgFlag <= 1'b0;
    else if (mismatch)   chgFlag <= 1'b1;
    else if (str.chgClr) chgFlag <= 1'b0;
  end

  // edge detector on the external-interrupt pin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) extPrev <= 1'b0;
    else        extPrev <= pinSync[EXT_BIT];
  end
  assign extEdge = extRise ? (pinSync[EXT_BIT] & ~extPrev)
                           : (~pinSync[EXT_BIT] & extPrev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          extFlag <= 1'b0;
    else if (extEdge)    extFlag <= 1'b1;
    else if (str.extClr) extFlag <= 1'b0;
  end

  // R6
  chg_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> chgFlag);
  // R9
  chg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chgFlag && !str.chgClr) |=> chgFlag);
  // R7
  out_excluded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chgFlag && (pinOe[W-1:CHG_LSB] == '1)) |=> !chgFlag);
  // R10
  ext_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (extRise && pinSync[EXT_BIT] && !extPrev) |=> extFlag);
  // R11
  ext_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!extRise && !pinSync[EXT_BIT] && extPrev) |=> extFlag);
  // R4
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    str.dirWr |=> (pinOe == ~$past(wdata)));
  // R3
  lat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    str.portWr |=> (pinOut == $past(wdata)));
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
  import gpio_chg_pkg::*;
#(
  parameter int W       = 8,
  parameter int CHG_LSB = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busEn,
  input  logic         busWe,
  input  logic         busAddr,
  input  logic [W-1:0] busWdata,
  output logic [W-1:0] busRdata,
  input  logic         pullupOffN,
  input  logic         extRise,
  input  logic         chgClr,
  input  logic         extClr,
  input  logic [W-1:0] pinIn,
  output logic [W-1:0] pinOe,
  output logic [W-1:0] pinOut,
  output logic [W-1:0] pullEn,
  output logic         chgFlag,
  output logic         extFlag
);
  strobe_t str;

  gpio_chg_ctrl u_ctrl (
    .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .chgClrIn(chgClr), .extClrIn(extClr), .str(str)
  );

  gpio_chg_dp #(.W(W), .CHG_LSB(CHG_LSB), .EXT_BIT(0)) u_dp (
    .clk(clk), .rst_n(rst_n), .str(str), .wdata(busWdata), .rdata(busRdata),
    .pullupOffN(pullupOffN), .extRise(extRise), .pinIn(pinIn),
    .pinOe(pinOe), .pinOut(pinOut), .pullEn(pullEn),
    .chgFlag(chgFlag), .extFlag(extFlag)
  );

  // R5
  always_comb begin
    pull_oe_chk: assert ((pullEn & pinOe) == '0);
  end
endmodule

// File: tb/gpio_chg_port_tb.sv
module gpio_chg_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busEn = 1'b0, busWe = 1'b0, busAddr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       pullupOffN = 1'b1, extRise = 1'b1, chgClr = 1'b0, extClr = 1'b0;
  logic [7:0] pinIn = '0;
  logic [7:0] pinOe, pinOut, pullEn;
  logic       chgFlag, extFlag;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  gpio_chg_port dut_i (
    .clk(clk), .rst_n(rst_n), .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pullupOffN(pullupOffN),
    .extRise(extRise), .chgClr(chgClr), .extClr(extClr), .pinIn(pinIn),
    .pinOe(pinOe), .pinOut(pinOut), .pullEn(pullEn),
    .chgFlag(chgFlag), .extFlag(extFlag)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic addr, input logic [7:0] d);
    busEn = 1; busWe = 1; busAddr = addr; busWdata = d;
    @(negedge clk);
    busEn = 0; busWe = 0;
  endtask

  task automatic busRead(input logic addr, output logic [7:0] d);
    busEn = 1; busWe = 0; busAddr = addr;
    #1 d = busRdata;
    @(negedge clk);
    busEn = 0;
  endtask

  task automatic pulseChgClr();
    chgClr = 1; @(negedge clk); chgClr = 0;
  endtask

  task automatic pulseExtClr();
    extClr = 1; @(negedge clk); extClr = 0;
  endtask

  // re-snapshot and clear the change flag
  task automatic settle();
    logic [7:0] d;
    waitN(3);
    busRead(1'b0, d);
    pulseChgClr();
  endtask

  task automatic t_reset();
    check("R1 pinOe", pinOe, 8'h00);
    check("R1 pinOut", pinOut, 8'h00);
    check("R1 flags", {6'b0, chgFlag, extFlag}, 8'h00);
  endtask

  task automatic t_direction();
    logic [7:0] d;
    busWrite(1'b1, 8'h3C);
    check("R2 pinOe", pinOe, 8'hC3);
    busRead(1'b1, d);
    check("R4 dir read", d, 8'h3C);
    busWrite(1'b0, 8'h5A);
    check("R2 pinOut", pinOut, 8'h5A);
    check("R3 write leaves dir", pinOe, 8'hC3);
    busWrite(1'b1, 8'hFF);
  endtask

  task automatic t_read_pins();
    logic [7:0] d;
    pinIn = 8'h0A;
    waitN(1);
    busRead(1'b0, d);
    check("R3 read before sync", d, 8'h00);
    busRead(1'b0, d);
    check("R3 read pins", d, 8'h0A);
    check("R3 latch unchanged", pinOut, 8'h5A);
    pinIn = 8'h00;
    settle();
  endtask

  task automatic t_pullups();
    busWrite(1'b1, 8'h0F);
    check("R5 pull off", pullEn, 8'h00);
    pullupOffN = 0; #1;
    check("R5 pull on inputs", pullEn, 8'h0F);
    pullupOffN = 1;
    busWrite(1'b1, 8'hFF);
  endtask

  task automatic t_change_basic();
    pinIn[5] = 1'b1;
    waitN(2);
    check("R6 not yet", {7'b0, chgFlag}, 8'h00);
    waitN(1);
    check("R6 set", {7'b0, chgFlag}, 8'h01);
  endtask

  task automatic t_clear_persist();
    // R9: clear while the mismatch is still live
    pulseChgClr();
    check("R9 clear loses", {7'b0, chgFlag}, 8'h01);
  endtask

  task automatic t_clear_after_read();
    logic [7:0] d;
    busRead(1'b0, d);
    pulseChgClr();
    check("R8 read ends mismatch", {7'b0, chgFlag}, 8'h00);
    waitN(3);
    check("R8 stays clear", {7'b0, chgFlag}, 8'h00);
    pinIn[7] = 1'b1;
    waitN(3);
    check("R6 second pin", {7'b0, chgFlag}, 8'h01);
    busWrite(1'b0, 8'h00);
    pulseChgClr();
    check("R8 write ends mismatch", {7'b0, chgFlag}, 8'h00);
  endtask

  task automatic t_lower_ignored();
    pinIn[2] = 1'b1;
    waitN(4);
    check("R6 lower pins ignored", {7'b0, chgFlag}, 8'h00);
    pinIn[2] = 1'b0;
    waitN(3);
  endtask

  task automatic t_output_excluded();
    busWrite(1'b1, 8'hBF);
    pinIn[6] = 1'b1;
    waitN(4);
    check("R7 output pin excluded", {7'b0, chgFlag}, 8'h00);
    busWrite(1'b1, 8'hFF);
    waitN(1);
    check("R7 back to input", {7'b0, chgFlag}, 8'h01);
    settle();
  endtask

  task automatic t_ext_rise();
    extRise = 1;
    pinIn[0] = 1'b1;
    waitN(2);
    check("R10 not yet", {7'b0, extFlag}, 8'h00);
    waitN(1);
    check("R10 rise sets", {7'b0, extFlag}, 8'h01);
    pulseExtClr();
    check("R11 extClr", {7'b0, extFlag}, 8'h00);
    pinIn[0] = 1'b0;
    waitN(4);
    check("R10 fall ignored", {7'b0, extFlag}, 8'h00);
  endtask

  task automatic t_ext_fall();
    extRise = 0;
    pinIn[0] = 1'b1;
    waitN(4);
    check("R11 rise ignored", {7'b0, extFlag}, 8'h00);
    pinIn[0] = 1'b0;
    waitN(3);
    check("R11 fall sets", {7'b0, extFlag}, 8'h01);
    pulseExtClr();
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    waitN(3);
    t_reset();
    rst_n = 1'b1;
    waitN(2);
    t_reset();
    t_direction();
    t_read_pins();
    t_pullups();
    t_change_basic();
    t_clear_persist();
    t_clear_after_read();
    t_lower_ignored();
    t_output_excluded();
    t_ext_rise();
    t_ext_fall();
    waitN(2);
    finishRun();
  end
endmodule